// File: doc/BRIEF.md
# Framed Word Serializer with Parity

This block sends one 64-bit word over a single asynchronous serial line as eight separate character frames. A client presents the word with a one-cycle strobe while the block is idle. The block latches the word and then emits the eight bytes, least significant byte first. Each byte goes out as a frame: a low start bit, eight data bits least significant bit first, one parity bit, and two high stop bits.

The bit period is a fixed number of clock cycles, set by a parameter. An internal divider produces the bit timing and restarts when a word is accepted, so every bit of every frame lasts exactly that many cycles. A parameter selects even or odd parity. The block raises `busy` for the whole transfer. When the transfer ends it drops `busy` and pulses `done` for one cycle. While it waits, the line rests high.

Top module: `word_frame_serializer`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the next cycle shows `tx_line` high, `busy` low and `done` low.
- R2: While idle the line is high. A high `load_valid` in an idle cycle is accepted at that edge, and the line goes low at once for a start bit lasting BIT_CYCLES clocks.
- R3: Each frame lasts 12 bit periods of BIT_CYCLES clocks each, in this order: start (low), eight data bits with the data LSB first, one parity bit, then two stop bits (high).
- R4: Byte k of the word is `load_word[8k+7:8k]`. Bytes go out in order k = 0 to 7, with no idle gap between frames.
- R5: With PARITY_ODD = 0 the parity bit is the XOR of the eight data bits. With PARITY_ODD = 1 it is that XOR inverted.
- R6: `busy` is high from the cycle after acceptance until the last stop bit of byte 7 ends. It then falls, and in that same cycle `done` is high for exactly one cycle.
- R7: The word is latched at acceptance. Changes to `load_word` during a transfer do not alter the bits sent.
- R8: A `load_valid` seen while busy is ignored. It does not restart or extend the transfer, and no new transfer begins after `done`.
- R9: A reset during a transfer aborts it. The line returns high and `busy` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load_valid | input | 1 | Strobe requesting transmission of `load_word` |
| load_word | input | 64 | Word to transmit; byte k at bits 8k+7:8k |
| busy | output | 1 | High while a word is being transmitted |
| done | output | 1 | One-cycle pulse when the last stop bit has ended |
| tx_line | output | 1 | Serial output, high when idle |

## Verification
The bench builds two copies with a bit period of 4 clocks: one with even parity and one with odd parity. Both copies receive the same stimulus. The short bit period makes a full 64-bit transfer only 384 cycles, so the bench can sweep 32 words whose bytes together cover all 256 byte values. It checks the line in every cycle against frames computed arithmetically, under both parity settings. The bench also replaces the latched word and strobes mid-transfer, and resets mid-transfer, to cover the capture, ignore and abort rules.

// File: rtl/sfs_pkg.sv
// Shared types for the framed word serializer.
// Assumes: one frame = start, data, parity, two stops.
package sfs_pkg;

    // Frame sequencing states, visited in declaration order per byte.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP_A = 3'd4,
        ST_STOP_B = 3'd5
    } sfs_state_t;

endpackage

// File: rtl/sfs_bit_timer.sv
// Bit-period timer: emits a one-cycle tick every BIT_CYCLES clocks.
// Assumes: restart realigns the period so the next tick comes
// BIT_CYCLES clocks after the restart edge.
module sfs_bit_timer #(
    parameter int BIT_CYCLES = 434
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Count clocks within the current bit period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign tick = (cnt_q == LAST);

    generate
        if (BIT_CYCLES > 1) begin : g_spacing_chk
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick) else $error("tick repeated"); // R3
        end
    endgenerate

endmodule

// File: rtl/sfs_byte_bank.sv
// Byte bank: latches a wide word as an array of byte lanes and
// returns the lane picked by a byte index.
// Assumes: load_en is a single-cycle capture request.
module sfs_byte_bank #(
    parameter int BYTES  = 8,
    parameter int BYTE_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_en,
    input  logic [BYTES*BYTE_W-1:0] word_in,
    input  logic [SEL_W-1:0]        sel,
    output logic [BYTE_W-1:0]       byte_out
);
    logic [BYTE_W-1:0] lane_q [BYTES];

    genvar g;
    generate
        for (g = 0; g < BYTES; g++) begin : g_lane
            // Capture one byte lane of the incoming word.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lane_q[g] <= '0;
                end else if (load_en) begin
                    lane_q[g] <= word_in[g*BYTE_W +: BYTE_W];
                end
            end
        end
    endgenerate

    assign byte_out = lane_q[sel];

    AST_LANE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!load_en) && $stable(sel)) |-> $stable(byte_out))
        else $error("byte lane changed without capture"); // R7

endmodule

// File: rtl/sfs_parity.sv
// Parity generator: XOR-reduces a byte in one parallel step.
// Assumes: ODD = 1 seeds the chain with 1, inverting the result.
module sfs_parity #(
    parameter int BYTE_W = 8,
    parameter bit ODD    = 1'b0
) (
    input  logic [BYTE_W-1:0] data,
    output logic              par
);
    // Fold every data bit into the seeded XOR chain.
    always_comb begin
        par = ODD;
        for (int i = 0; i < BYTE_W; i++) begin
            par = par ^ data[i];
        end
    end
endmodule

// File: rtl/word_frame_serializer.sv
// Framed word serializer: sends a latched word as consecutive byte
// frames (start, data LSB first, parity, two stops) on one line.
// Assumes: BYTE_W >= 2; a strobe is only accepted while idle.
module word_frame_serializer
    import sfs_pkg::*;
#(
    parameter int BYTES      = 8,
    parameter int BYTE_W     = 8,
    parameter int BIT_CYCLES = 434,
    parameter bit PARITY_ODD = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_valid,
    input  logic [BYTES*BYTE_W-1:0] load_word,
    output logic                    busy,
    output logic                    done,
    output logic                    tx_line
);
    localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [IDX_W-1:0] BYTE_LAST = IDX_W'(BYTES - 1);
    localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(BYTE_W - 1);

    sfs_state_t         state_q;
    logic [IDX_W-1:0]   byte_idx_q;
    logic [BIT_W-1:0]   bit_idx_q;
    logic               done_q;
    logic               accept;
    logic               tick;
    logic [BYTE_W-1:0]  cur_byte;
    logic               par_bit;

    assign accept = load_valid && (state_q == ST_IDLE);

    sfs_bit_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .tick    (tick)
    );

    sfs_byte_bank #(.BYTES(BYTES), .BYTE_W(BYTE_W), .SEL_W(IDX_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (accept),
        .word_in  (load_word),
        .sel      (byte_idx_q),
        .byte_out (cur_byte)
    );

    sfs_parity #(.BYTE_W(BYTE_W), .ODD(PARITY_ODD)) u_par (
        .data (cur_byte),
        .par  (par_bit)
    );

    // Sequence frames and bytes, advancing one bit per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            byte_idx_q <= '0;
            bit_idx_q  <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (load_valid) begin
                        state_q    <= ST_START;
                        byte_idx_q <= '0;
                        bit_idx_q  <= '0;
                    end
                end
                ST_START: begin
                    if (tick) state_q <= ST_DATA;
                end
                ST_DATA: begin
                    if (tick) begin
                        if (bit_idx_q == BIT_LAST) begin
                            bit_idx_q <= '0;
                            state_q   <= ST_PARITY;
                        end else begin
                            bit_idx_q <= bit_idx_q + BIT_W'(1);
                        end
                    end
                end
                ST_PARITY: begin
                    if (tick) state_q <= ST_STOP_A;
                end
                ST_STOP_A: begin
                    if (tick) state_q <= ST_STOP_B;
                end
                ST_STOP_B: begin
                    if (tick) begin
                        if (byte_idx_q == BYTE_LAST) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            byte_idx_q <= byte_idx_q + IDX_W'(1);
                            state_q    <= ST_START;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the serial line from the current frame position.
    always_comb begin
        case (state_q)
            ST_START:  tx_line = 1'b0;
            ST_DATA:   tx_line = cur_byte[bit_idx_q];
            ST_PARITY: tx_line = par_bit;
            default:   tx_line = 1'b1;
        endcase
    end

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_line) else $error("line low while idle"); // R2
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx_line) else $error("no start bit"); // R2
    AST_STOP_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(tx_line)) else $error("last bit not a stop"); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R6
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))) else $error("done not at end of busy"); // R6

endmodule

// File: tb/word_frame_serializer_test.sv
module word_frame_serializer_test;
    localparam int B     = 4;
    localparam int FRAME = 12 * B;
    localparam int TOTAL = 8 * FRAME;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_valid = 1'b0;
    logic [63:0] load_word = '0;
    logic        busy_e, done_e, tx_e;
    logic        busy_o, done_o, tx_o;
    int          checks = 0;
    int          failures = 0;

    always #5 clk = ~clk;

    word_frame_serializer #(.BYTES(8), .BYTE_W(8), .BIT_CYCLES(B), .PARITY_ODD(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_word(load_word),
        .busy(busy_e), .done(done_e), .tx_line(tx_e)
    );

    word_frame_serializer #(.BYTES(8), .BYTE_W(8), .BIT_CYCLES(B), .PARITY_ODD(1'b1)) uut_odd (
        .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_word(load_word),
        .busy(busy_o), .done(done_o), .tx_line(tx_o)
    );

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected line level k cycles after acceptance.
    function automatic logic exp_bit(input logic [63:0] w, input int k, input logic odd);
        int f = k / FRAME;
        int p = (k % FRAME) / B;
        logic [7:0] b = w[f*8 +: 8];
        if (p == 0) return 1'b0;
        if (p <= 8) return b[p-1];
        if (p == 9) return (^b) ^ odd;
        return 1'b1;
    endfunction

    function automatic string pos_tag(input int k);
        int p = (k % FRAME) / B;
        if (p == 0) return "R2";
        if (p <= 8) return "R3/R4";
        if (p == 9) return "R5";
        return "R3";
    endfunction

    task automatic run_word(input logic [63:0] w, input bit inject);
        @(negedge clk);
        load_word  = w;
        load_valid = 1'b1;
        @(negedge clk);
        load_valid = 1'b0;
        for (int k = 0; k <= TOTAL + 1; k++) begin
            if (k > 0) @(negedge clk);
            if (inject && k == 50) begin load_word = ~w; load_valid = 1'b1; end
            if (inject && k == 60) load_valid = 1'b0;
            if (k < TOTAL) begin
                check(tx_e == exp_bit(w, k, 1'b0), inject ? "R7" : pos_tag(k), 64'(tx_e), 64'(exp_bit(w, k, 1'b0)));
                check(tx_o == exp_bit(w, k, 1'b1), inject ? "R7" : pos_tag(k), 64'(tx_o), 64'(exp_bit(w, k, 1'b1)));
                check(busy_e && busy_o, "R6", {62'd0, busy_e, busy_o}, 64'd3);
            end else if (k == TOTAL) begin
                check(done_e && done_o && !busy_e && !busy_o, "R6",
                      {60'd0, done_e, done_o, busy_e, busy_o}, 64'hC);
                check(tx_e && tx_o, "R3", {62'd0, tx_e, tx_o}, 64'd3);
            end else begin
                check(!done_e && !done_o && !busy_e && !busy_o && tx_e && tx_o,
                      inject ? "R8" : "R6",
                      {58'd0, done_e, done_o, busy_e, busy_o, tx_e, tx_o}, 64'h3);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(tx_e && tx_o && !busy_e && !busy_o && !done_e && !done_o, "R1",
              {58'd0, tx_e, tx_o, busy_e, busy_o, done_e, done_o}, 64'h30);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_e && !busy_e, "R2", {62'd0, tx_e, busy_e}, 64'd2);

        run_word(64'h0, 1'b0);
        run_word(64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        run_word(64'hA5A5_5A5A_0F0F_F0F0, 1'b0);
        // R7 and R8: word change and strobe while busy
        run_word(64'h0123_4567_89AB_CDEF, 1'b1);

        // Sweep: 32 words covering all byte values (R4, R5)
        for (int w = 0; w < 32; w++) begin
            logic [63:0] word;
            for (int i = 0; i < 8; i++) word[i*8 +: 8] = 8'(w * 8 + i);
            run_word(word, 1'b0);
        end

        // R9: reset during a transfer
        @(negedge clk);
        load_word  = 64'h1122_3344_5566_7788;
        load_valid = 1'b1;
        @(negedge clk);
        load_valid = 1'b0;
        repeat (100) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(tx_e && tx_o && !busy_e && !busy_o && !done_e, "R9",
              {59'd0, tx_e, tx_o, busy_e, busy_o, done_e}, 64'h18);
        rst_n = 1'b1;
        repeat (2 * B) @(negedge clk);
        check(tx_e && !busy_e, "R9", {62'd0, tx_e, busy_e}, 64'd2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule